// File: doc/BRIEF.md
# Segmented Sample-Memory DMA Engine

This block moves bytes between a host byte stream and a 1 MiB sample memory. Software programs a 16-bit segment register (16-byte granularity), a 4-bit nibble register that supplies the byte position inside a segment, and an 8-bit control register. Setting the request bit in the control register starts a transfer. The engine then presents one sample-memory address per byte beat. On upload it accepts host bytes and writes them to memory. On download it offers memory bytes to the host.

A static `wide16` input selects 16-bit channel operation. In that mode the linear address is remapped: the top two address bits stay in place and the remaining segment bits are doubled. Each count unit then moves a low byte followed by a high byte. On upload an optional sign-bit flip converts signed and unsigned samples.

The host side marks the last unit of a block with `tcIn`. At that point the engine stops, advances the segment and nibble registers by the block length, and can raise an interrupt. Reading the control register reports the status and clears it.

Top module: `dma_engine`

## Requirements
- R1: With `wide16`=0, the address of unit u in a block is (segment*16 + nibble + u) modulo 2^20, one byte per unit.
- R2: With `wide16`=1, let L = segment*16 + nibble. The base is (L & 0xC0000) + 2*(L & 0x1FFF0). Unit u puts its low byte at base+2u and its high byte at base+2u+1, modulo 2^20, with the low byte first.
- R3: Control bit 1 selects the direction. 0 is upload: `hostInReady` is high and each accepted byte is written with `memWrEn`. 1 is download: `hostOutValid` is high and `hostOutData` equals `memRdData` unchanged. The two handshake outputs are never high together.
- R4: On upload with control bit 7 set, bit 7 of the byte is inverted. The exception is a low byte (every byte when `wide16`=0) while control bit 6 is set, which passes unchanged. On download no byte is altered.
- R5: After a block of N units, the segment becomes segment + (N>>4) modulo 2^16, and the nibble becomes (nibble + N) & 0xF. The nibble carry is discarded.
- R6: `tcIn` takes effect only on a beat that completes a unit (the high byte when `wide16`=1). Such a beat clears control bit 0, and the engine then accepts and offers no more bytes.
- R7: A block end with control bit 5 set makes `dmaIrq` high from the next cycle.
- R8: `ctrlRdData` shows the stored control byte, OR bit 2 when `wide16`=1, OR bit 6 while a completion interrupt is pending. A cycle with `ctrlRdEn` high clears stored bits 2 and 6 and the pending flag, so `dmaIrq` is low the next cycle.
- R9: After reset the control byte, the interrupt and both handshake outputs are zero. Writing the control register (select 0) with bit 0 set starts a block at unit 0. Select 1 writes the segment and select 2 writes the nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wide16 | input | 1 | Static 16-bit channel mode |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 control, 1 segment, 2 nibble |
| regWrData | input | 16 | Register write data |
| ctrlRdEn | input | 1 | Control read strobe (clears status) |
| ctrlRdData | output | 8 | Control read value |
| hostInValid | input | 1 | Upload byte valid |
| hostInData | input | 8 | Upload byte |
| hostInReady | output | 1 | Engine accepts upload byte |
| hostOutValid | output | 1 | Download byte valid |
| hostOutData | output | 8 | Download byte |
| hostOutReady | input | 1 | Host accepts download byte |
| tcIn | input | 1 | Last unit of the block |
| memAddr | output | 20 | Sample-memory byte address |
| memWrEn | output | 1 | Sample-memory write strobe |
| memWrData | output | 8 | Sample-memory write data |
| memRdData | input | 8 | Sample-memory read data (same cycle) |
| dmaIrq | output | 1 | Completion interrupt |

## Verification
The assertions assume that `wide16` changes only while no block is running. They also assume that register writes and control reads never coincide with a byte beat, because the address-step property attributes any address change to the beat alone. The stimulus follows these rules. It switches the channel mode only between blocks, programs the registers only while the engine is idle, and issues control reads only after a block has ended. Random stalls on the host handshake vary the beat timing without breaking these rules.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef struct packed {
    logic wrSeg;
    logic wrNib;
    logic restart;
    logic unitDone;
    logic blockEnd;
    logic hiPhase;
    logic upBeat;
    logic flipMsb;
  } dmaStrobe_t;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_SEG  = 2'd1;
  localparam logic [1:0] SEL_NIB  = 2'd2;
endpackage

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wide16,
  input  logic       regWrEn,
  input  logic [1:0] regSel,
  input  logic [7:0] ctrlWrData,
  input  logic       ctrlRdEn,
  output logic [7:0] ctrlRdData,
  input  logic       hostInValid,
  output logic       hostInReady,
  output logic       hostOutValid,
  input  logic       hostOutReady,
  input  logic       tcIn,
  output logic       dmaIrq,
  output dmaStrobe_t strobe
);
  logic [7:0] ctrlReg, ctrlNext;
  logic       tcPend, hiPhase, beat, unitDone, blockEnd, ctrlWr, lowByte;

  assign ctrlWr       = regWrEn && (regSel == SEL_CTRL);
  assign hostInReady  = ctrlReg[0] && !ctrlReg[1];
  assign hostOutValid = ctrlReg[0] && ctrlReg[1];
  assign beat         = (hostInValid && hostInReady) || (hostOutValid && hostOutReady);
  assign unitDone     = beat && (!wide16 || hiPhase);
  assign blockEnd     = unitDone && tcIn;
  assign lowByte      = !wide16 || !hiPhase;
  assign ctrlRdData   = ctrlReg | {1'b0, tcPend, 3'b000, wide16, 2'b00};
  assign dmaIrq       = tcPend;

  always_comb begin
    ctrlNext = ctrlReg;
    if (ctrlRdEn) begin
      ctrlNext[2] = 1'b0;
      ctrlNext[6] = 1'b0;
    end
    if (blockEnd) ctrlNext[0] = 1'b0;
    if (ctrlWr)   ctrlNext = ctrlWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      tcPend  <= 1'b0;
      hiPhase <= 1'b0;
    end else begin
      ctrlReg <= ctrlNext;
      if (blockEnd && ctrlReg[5]) tcPend <= 1'b1;
      else if (ctrlRdEn)          tcPend <= 1'b0;
      if (ctrlWr || !wide16) hiPhase <= 1'b0;
      else if (beat)         hiPhase <= !hiPhase;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.wrSeg    = regWrEn && (regSel == SEL_SEG);
    strobe.wrNib    = regWrEn && (regSel == SEL_NIB);
    strobe.restart  = ctrlWr;
    strobe.unitDone = unitDone;
    strobe.blockEnd = blockEnd;
    strobe.hiPhase  = hiPhase;
    strobe.upBeat   = hostInValid && hostInReady;
    strobe.flipMsb  = ctrlReg[7] && !ctrlReg[1] && !(lowByte && ctrlReg[6]);
  end
endmodule

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int NIB_W  = 4,
  parameter int DATA_W = 8,
  localparam int ADDR_W = SEG_W + NIB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wide16,
  input  logic [SEG_W-1:0]  regWrData,
  input  dmaStrobe_t        strobe,
  input  logic [DATA_W-1:0] hostInData,
  output logic [DATA_W-1:0] hostOutData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData
);
  localparam logic [ADDR_W-1:0] HiMask  = {2'b11, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] MidMask = ADDR_W'((1 << (ADDR_W-3)) - 1) & ~ADDR_W'((1 << NIB_W) - 1);

  logic [SEG_W-1:0]  segReg;
  logic [NIB_W-1:0]  nibReg;
  logic [ADDR_W-1:0] unitCnt, unitsDone, linear, base, offs;

  assign unitsDone = unitCnt + ADDR_W'(1);
  assign linear    = {segReg, {NIB_W{1'b0}}} + ADDR_W'(nibReg);
  assign base      = wide16 ? ((linear & HiMask) + ((linear & MidMask) << 1)) : linear;
  assign offs      = wide16 ? {unitCnt[ADDR_W-2:0], strobe.hiPhase} : unitCnt;
  assign memAddr   = base + offs;
  assign memWrEn   = strobe.upBeat;
  assign memWrData = hostInData ^ {strobe.flipMsb, {(DATA_W-1){1'b0}}};
  assign hostOutData = memRdData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segReg  <= '0;
      nibReg  <= '0;
      unitCnt <= '0;
    end else begin
      if (strobe.wrSeg) segReg <= regWrData;
      else if (strobe.blockEnd) segReg <= segReg + unitsDone[ADDR_W-1:NIB_W];
      if (strobe.wrNib) nibReg <= regWrData[NIB_W-1:0];
      else if (strobe.blockEnd) nibReg <= nibReg + unitsDone[NIB_W-1:0];
      if (strobe.restart || strobe.blockEnd) unitCnt <= '0;
      else if (strobe.unitDone) unitCnt <= unitsDone;
    end
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int NIB_W  = 4,
  parameter int DATA_W = 8,
  localparam int ADDR_W = SEG_W + NIB_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wide16,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [SEG_W-1:0]  regWrData,
  input  logic              ctrlRdEn,
  output logic [7:0]        ctrlRdData,
  input  logic              hostInValid,
  input  logic [DATA_W-1:0] hostInData,
  output logic              hostInReady,
  output logic              hostOutValid,
  output logic [DATA_W-1:0] hostOutData,
  input  logic              hostOutReady,
  input  logic              tcIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              dmaIrq
);
  dmaStrobe_t strobe;

  dma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wide16(wide16), .regWrEn(regWrEn), .regSel(regSel),
    .ctrlWrData(regWrData[7:0]), .ctrlRdEn(ctrlRdEn), .ctrlRdData(ctrlRdData),
    .hostInValid(hostInValid), .hostInReady(hostInReady), .hostOutValid(hostOutValid),
    .hostOutReady(hostOutReady), .tcIn(tcIn), .dmaIrq(dmaIrq), .strobe(strobe)
  );

  dma_datapath #(.SEG_W(SEG_W), .NIB_W(NIB_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .wide16(wide16), .regWrData(regWrData), .strobe(strobe),
    .hostInData(hostInData), .hostOutData(hostOutData), .memAddr(memAddr),
    .memWrEn(memWrEn), .memWrData(memWrData), .memRdData(memRdData)
  );
endmodule

// File: rtl/dma_engine_checks.sv
module dma_engine_checks #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              wide16,
  input logic              regWrEn,
  input logic              ctrlRdEn,
  input logic              hostInReady,
  input logic              hostOutValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              dmaIrq,
  input logic              ctrlBit5,
  input logic              blockEnd,
  input logic              upBeat,
  input logic              hiPhase
);
  p_dir_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(hostInReady && hostOutValid));

  p_low_then_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wide16 && upBeat && !hiPhase && !regWrEn) |=> (memAddr == $past(memAddr) + ADDR_W'(1)));

  p_req_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (blockEnd && !regWrEn) |=> (!hostInReady && !hostOutValid));

  p_irq_raise_r7: assert property (@(posedge clk) disable iff (!rstN)
    (blockEnd && ctrlBit5) |=> dmaIrq);

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaIrq) |-> $past(blockEnd));

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRdEn && !blockEnd) |=> !dmaIrq);
endmodule

bind dma_engine dma_engine_checks #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wide16(wide16), .regWrEn(regWrEn), .ctrlRdEn(ctrlRdEn),
  .hostInReady(hostInReady), .hostOutValid(hostOutValid), .memAddr(memAddr),
  .dmaIrq(dmaIrq), .ctrlBit5(ctrlRdData[5]), .blockEnd(strobe.blockEnd),
  .upBeat(strobe.upBeat), .hiPhase(strobe.hiPhase)
);

// File: tb/dma_engine_bench.sv
`timescale 1ns/1ps
module dma_engine_bench;
  logic        clk = 0, rstN = 0, wide16 = 0;
  logic        regWrEn = 0, ctrlRdEn = 0, hostInValid = 0, hostOutReady = 0, tcIn = 0;
  logic [1:0]  regSel = 0;
  logic [15:0] regWrData = 0;
  logic [7:0]  hostInData = 0, ctrlRdData, hostOutData, memWrData, memRdData;
  logic        hostInReady, hostOutValid, memWrEn, dmaIrq;
  logic [19:0] memAddr;

  int vecs = 0, fails = 0;
  logic [15:0] mSeg = 0;
  logic [3:0]  mNib = 0;
  logic [7:0]  mCtrl = 0;
  logic        mPend = 0;

  always #4 clk = ~clk;
  assign memRdData = memAddr[7:0] ^ memAddr[15:8] ^ 8'h3C;

  dma_engine u_dma_engine (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] expAddr(input logic [15:0] s, input logic [3:0] n,
                                          input bit w, input int u, input int h);
    logic [19:0] lin, b;
    lin = {s, 4'h0} + 20'(n);
    b = w ? ((lin & 20'hC0000) + ((lin & 20'h1FFF0) << 1)) : lin;
    return w ? b + 20'(2*u + h) : b + 20'(u);
  endfunction

  task automatic wrReg(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); regWrEn = 1; regSel = s; regWrData = d;
    @(negedge clk); regWrEn = 0;
    if (s == 0) mCtrl = d[7:0]; else if (s == 1) mSeg = d; else mNib = d[3:0];
  endtask

  task automatic rdCtrl();
    logic [7:0] e;
    @(negedge clk); ctrlRdEn = 1; #2;
    e = mCtrl | (wide16 ? 8'h04 : 8'h00) | (mPend ? 8'h40 : 8'h00);
    chk(ctrlRdData == e, "R8 ctrl read", 32'(ctrlRdData), 32'(e));
    @(negedge clk); ctrlRdEn = 0;
    mCtrl &= 8'hBB; mPend = 0;
    chk(dmaIrq == 0, "R8 irq cleared by read", 32'(dmaIrq), 0);
  endtask

  task automatic runBlock(input logic [7:0] c, input int units, input bit earlyTc);
    int phases = wide16 ? 2 : 1;
    bit up = !c[1];
    wrReg(0, {8'h00, c});
    for (int u = 0; u < units; u++) begin
      for (int h = 0; h < phases; h++) begin
        logic [19:0] ea;
        logic [7:0] d, ed;
        bit inv;
        @(negedge clk);
        while (($urandom % 4) == 0) begin
          hostInValid = 0; hostOutReady = 0; tcIn = 1; @(negedge clk);
        end
        d = 8'($urandom);
        hostInData = d; hostInValid = up; hostOutReady = !up;
        tcIn = ((u == units-1) && (h == phases-1)) || (earlyTc && u == 0 && h == 0);
        #2;
        ea = expAddr(mSeg, mNib, wide16, u, h);
        chk(memAddr == ea, wide16 ? "R2 address" : "R1 address", 32'(memAddr), 32'(ea));
        chk(up ? hostInReady : hostOutValid, "R6 engine active", 0, 1);
        if (up) begin
          inv = c[7] && !((!wide16 || h == 0) && c[6]);
          ed = d ^ {inv, 7'b0};
          chk(memWrEn && memWrData == ed, "R4 upload byte", 32'(memWrData), 32'(ed));
        end else begin
          ed = ea[7:0] ^ ea[15:8] ^ 8'h3C;
          chk(!memWrEn && hostOutData == ed, "R3 download byte", 32'(hostOutData), 32'(ed));
        end
      end
    end
    @(negedge clk); hostInValid = 0; hostOutReady = 0; tcIn = 0; #2;
    mCtrl[0] = 0;
    if (c[5]) mPend = 1;
    mSeg = mSeg + 16'(units >> 4);
    mNib = mNib + 4'(units);
    chk(!hostInReady && !hostOutValid, "R6 stopped", 32'({hostInReady, hostOutValid}), 0);
    chk(dmaIrq == mPend, "R7 irq", 32'(dmaIrq), 32'(mPend));
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1; #2;
    chk(ctrlRdData == 0 && !dmaIrq, "R9 reset ctrl/irq", 32'({ctrlRdData, dmaIrq}), 0);
    chk(!hostInReady && !hostOutValid, "R9 reset idle", 32'({hostInReady, hostOutValid}), 0);

    wrReg(1, 16'h1234); wrReg(2, 16'h0005);
    runBlock(8'h01, 3, 0);               // R9 start, R1
    runBlock(8'h21, 8, 0);               // R5 nibble carry dropped, R7
    rdCtrl();                            // R8 pending bit
    runBlock(8'h81, 2, 0);               // R1 address after carry drop, R4
    wrReg(1, 16'hFFFF); wrReg(2, 16'h000F);
    runBlock(8'h83, 3, 0);               // R1 wrap, R3 download unaltered
    wide16 = 1;
    wrReg(1, 16'h7FFF); wrReg(2, 16'h0003);
    runBlock(8'hC1, 2, 1);               // R2 remap, R4 high flip, R6 early tc ignored
    rdCtrl();                            // R8 bit 2 forced
    wide16 = 0;
    runBlock(8'h01, 40, 0);              // R5 segment advance
    for (int i = 0; i < 20; i++) begin
      logic [7:0] c;
      wide16 = 1'($urandom);
      wrReg(1, 16'($urandom)); wrReg(2, 16'($urandom));
      c = {1'($urandom), 1'($urandom), 1'($urandom), 2'b00, 1'($urandom), 1'($urandom), 1'b1};
      runBlock(c, 1 + ($urandom % 40), 0);
      if (($urandom % 2) == 0) rdCtrl();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule